// File: doc/BRIEF.md
# Virtual-Frame Circular Buffer Translator

This block sits in the address path in front of an on-chip SRAM. It lets initiators treat each of a set of small circular buffer regions as a larger virtual video frame. A producer can then write a frame slice by slice while a consumer reads it, and both use plain frame addresses. Each buffer has a descriptor with four values: where its virtual window starts, how long the window is, where its SRAM region starts, and the region size given as a power of two.

On every request the block compares the incoming address with all enabled windows. It picks the lowest-numbered window that matches and folds the offset into that buffer's region: the offset is reduced modulo the region size and added to the region start. The result is a translated address on the same cycle, with no register in the path. An access that matches no enabled window, or that arrives while circular mode is off, leaves unchanged and raises a miss flag. Reads and writes go through the same decode and share no pointer state. Keeping writers ahead of readers is the initiators' job.

Configuration uses a one-cycle write port. Each write lands in a register at the clock edge, and translation uses the new value from the next cycle on.

Top module: `vframe_xlate`

## Requirements
- R1: After reset all enables and descriptors are zero, so every valid request misses and its address passes through unchanged.
- R2: Config word 0 is the enable register. Bit 0 is the global circular-mode enable, and bit 16+n enables buffer n. Buffer n translates only while both bits are 1. With the global bit at 0 no request hits.
- R3: For buffer n, config word 1+4n+f holds field f. f=0 is the virtual window base, f=1 the window length, f=2 the SRAM region start, and f=3 the log2 of the region size. A write changes translation from the cycle after its clock edge, not before.
- R4: A request matches buffer n when base <= address and address - base < length. A length of 0 never matches.
- R5: On a hit the output address is region start + ((address - base) mod 2^log2size), taken modulo 2^ADDR_W. The window base maps to the region start, and offsets past the region size wrap back to it.
- R6: Translation is combinational. The output follows a change of the request address within the same cycle.
- R7: A valid request with no match raises miss, keeps hit low, drives the buffer index to 0 and passes the address through unchanged.
- R8: When several enabled windows match, the lowest-numbered buffer is used and its index appears on the buffer-index output.
- R9: While no request is valid, hit and miss are both low.
- R10: A window length that is not a multiple of the region size is allowed. The last window address then maps partway into the region.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cfgValid | input | 1 | Config write strobe |
| cfgAddr | input | CFG_AW | Config word index |
| cfgData | input | 32 | Config write data |
| reqValid | input | 1 | Request valid (read or write) |
| reqAddr | input | ADDR_W | Virtual request address |
| xlateAddr | output | ADDR_W | Translated or passed-through address |
| hit | output | 1 | Request translated by a buffer |
| miss | output | 1 | Valid request matched no enabled buffer |
| hitBuf | output | IDX_W | Index of the translating buffer |

## Verification
The bench builds the block with NUM_BUF=4 and ADDR_W=16. Four buffers are enough to give each one its own role: two windows that overlap for priority, one window that wraps several times with a length that is not a multiple of the region, and one buffer that is programmed but left disabled. The 16-bit addresses keep every expected value short enough to work out by hand, from window edges to wrap points. The same settings also let the bench check the timing of a descriptor rewrite against a clock edge.

// File: rtl/vfcb_pkg.sv
package vfcb_pkg;
  typedef enum logic [1:0] {
    FLD_VBASE = 2'd0,
    FLD_VLEN  = 2'd1,
    FLD_SBASE = 2'd2,
    FLD_LOG2  = 2'd3
  } fieldE;

  typedef struct packed {
    logic  descWe;
    fieldE field;
  } cfgStrobeT;
endpackage

// File: rtl/vfcb_ctrl.sv
module vfcb_ctrl
  import vfcb_pkg::*;
#(
  parameter int NUM_BUF = 12,
  parameter int ADDR_W  = 32,
  parameter int CFG_AW  = 6
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cfgValid,
  input  logic [CFG_AW-1:0]  cfgAddr,
  input  logic [31:0]        cfgData,
  output cfgStrobeT          strobe,
  output logic [NUM_BUF-1:0] bufSel,
  output logic [ADDR_W-1:0]  wrData,
  output logic               globalEn,
  output logic [NUM_BUF-1:0] bufEn
);
  localparam int EN_LSB = 16;

  logic [CFG_AW-1:0] descIdx;
  logic              unusedOk;

  assign descIdx  = cfgAddr - CFG_AW'(1);
  assign wrData   = cfgData[ADDR_W-1:0];
  assign unusedOk = &{1'b0, cfgData};

  always_comb begin
    strobe.descWe = cfgValid && (cfgAddr != '0);
    strobe.field  = fieldE'(descIdx[1:0]);
    for (int n = 0; n < NUM_BUF; n++) begin
      bufSel[n] = strobe.descWe && ((descIdx >> 2) == CFG_AW'(n));
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      globalEn <= 1'b0;
      bufEn    <= '0;
    end else if (cfgValid && cfgAddr == '0) begin
      globalEn <= cfgData[0];
      bufEn    <= cfgData[EN_LSB +: NUM_BUF];
    end
  end

  // R2: the enable register takes the written bits at the next edge
  a_r2_enable_update: assert property (@(posedge clk) disable iff (!rstN)
    (cfgValid && cfgAddr == '0) |=> (globalEn == $past(cfgData[0]) &&
                                     bufEn == $past(cfgData[EN_LSB +: NUM_BUF])));

  // R3: at most one descriptor is selected per write
  a_r3_single_select: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(bufSel));
endmodule

// File: rtl/vfcb_datapath.sv
module vfcb_datapath
  import vfcb_pkg::*;
#(
  parameter int NUM_BUF = 12,
  parameter int ADDR_W  = 32,
  parameter int LOG_W   = 6,
  parameter int IDX_W   = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  cfgStrobeT          strobe,
  input  logic [NUM_BUF-1:0] bufSel,
  input  logic [ADDR_W-1:0]  wrData,
  input  logic               globalEn,
  input  logic [NUM_BUF-1:0] bufEn,
  input  logic               reqValid,
  input  logic [ADDR_W-1:0]  reqAddr,
  output logic [ADDR_W-1:0]  xlateAddr,
  output logic               hit,
  output logic               miss,
  output logic [IDX_W-1:0]   hitBuf
);
  logic [ADDR_W-1:0] vBase   [NUM_BUF];
  logic [ADDR_W-1:0] vLen    [NUM_BUF];
  logic [ADDR_W-1:0] sBase   [NUM_BUF];
  logic [LOG_W-1:0]  sizeLog [NUM_BUF];
  logic [ADDR_W-1:0] mapped  [NUM_BUF];
  logic [NUM_BUF-1:0] matchVec;

  for (genvar n = 0; n < NUM_BUF; n++) begin : g_buf
    logic [ADDR_W-1:0] offset;
    logic [ADDR_W-1:0] wrapMask;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        vBase[n]   <= '0;
        vLen[n]    <= '0;
        sBase[n]   <= '0;
        sizeLog[n] <= '0;
      end else if (bufSel[n]) begin
        case (strobe.field)
          FLD_VBASE: vBase[n]   <= wrData;
          FLD_VLEN:  vLen[n]    <= wrData;
          FLD_SBASE: sBase[n]   <= wrData;
          FLD_LOG2:  sizeLog[n] <= wrData[LOG_W-1:0];
          default: ;
        endcase
      end
    end

    assign offset      = reqAddr - vBase[n];
    assign wrapMask    = ~({ADDR_W{1'b1}} << sizeLog[n]);
    assign matchVec[n] = globalEn && bufEn[n] && (reqAddr >= vBase[n]) &&
                         (offset < vLen[n]);
    assign mapped[n]   = sBase[n] + (offset & wrapMask);
  end

  always_comb begin
    hit       = 1'b0;
    hitBuf    = '0;
    xlateAddr = reqAddr;
    for (int n = NUM_BUF - 1; n >= 0; n--) begin
      if (reqValid && matchVec[n]) begin
        hit       = 1'b1;
        hitBuf    = IDX_W'(n);
        xlateAddr = mapped[n];
      end
    end
    miss = reqValid && !hit;
  end

  // R7: a miss leaves the address untouched
  a_r7_miss_passthrough: assert property (@(posedge clk) disable iff (!rstN)
    miss |-> (xlateAddr == reqAddr && hitBuf == '0));

  // R9: no flags without a request
  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |-> (!hit && !miss));

  // R2: global mode off means nothing is translated
  a_r2_global_off: assert property (@(posedge clk) disable iff (!rstN)
    !globalEn |-> !hit);

  // R5: the window base lands on the region start
  a_r5_base_to_start: assert property (@(posedge clk) disable iff (!rstN)
    (hit && reqAddr == vBase[hitBuf]) |-> xlateAddr == sBase[hitBuf]);

  // R8: no lower-numbered buffer matched when a hit is reported
  a_r8_lowest_wins: assert property (@(posedge clk) disable iff (!rstN)
    hit |-> ((matchVec & ((NUM_BUF'(1) << hitBuf) - NUM_BUF'(1))) == '0));

  // R7: hit and miss never together
  a_r7_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(hit && miss));
endmodule

// File: rtl/vframe_xlate.sv
module vframe_xlate
  import vfcb_pkg::*;
#(
  parameter int NUM_BUF = 12,
  parameter int ADDR_W  = 32,
  localparam int CFG_AW = $clog2(1 + 4 * NUM_BUF),
  localparam int IDX_W  = (NUM_BUF > 1) ? $clog2(NUM_BUF) : 1,
  localparam int LOG_W  = $clog2(ADDR_W) + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgValid,
  input  logic [CFG_AW-1:0] cfgAddr,
  input  logic [31:0]       cfgData,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqAddr,
  output logic [ADDR_W-1:0] xlateAddr,
  output logic              hit,
  output logic              miss,
  output logic [IDX_W-1:0]  hitBuf
);
  cfgStrobeT          strobe;
  logic [NUM_BUF-1:0] bufSel;
  logic [NUM_BUF-1:0] bufEn;
  logic [ADDR_W-1:0]  wrData;
  logic               globalEn;

  vfcb_ctrl #(.NUM_BUF(NUM_BUF), .ADDR_W(ADDR_W), .CFG_AW(CFG_AW)) u_ctrl (
    .clk(clk), .rstN(rstN), .cfgValid(cfgValid), .cfgAddr(cfgAddr),
    .cfgData(cfgData), .strobe(strobe), .bufSel(bufSel), .wrData(wrData),
    .globalEn(globalEn), .bufEn(bufEn)
  );

  vfcb_datapath #(.NUM_BUF(NUM_BUF), .ADDR_W(ADDR_W), .LOG_W(LOG_W),
                  .IDX_W(IDX_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .bufSel(bufSel), .wrData(wrData),
    .globalEn(globalEn), .bufEn(bufEn), .reqValid(reqValid), .reqAddr(reqAddr),
    .xlateAddr(xlateAddr), .hit(hit), .miss(miss), .hitBuf(hitBuf)
  );
endmodule

// File: tb/tb_vframe_xlate.sv
module tb_vframe_xlate;
  localparam int NB = 4;
  localparam int AW = 16;
  localparam int CAW = $clog2(1 + 4 * NB);
  localparam int NV = 14;

  // address, expected output, expected hit, expected buffer
  localparam logic [15:0] V_ADDR [NV] = '{16'h1000, 16'h10FF, 16'h1100, 16'h127F,
    16'h1280, 16'h0FFF, 16'h2000, 16'h2045, 16'h2100, 16'h214F, 16'h2150,
    16'h21FF, 16'h2200, 16'h3000};
  localparam logic [15:0] V_EXP [NV] = '{16'h8000, 16'h80FF, 16'h8000, 16'h807F,
    16'h1280, 16'h0FFF, 16'h9000, 16'h9005, 16'h9000, 16'h900F, 16'hA050,
    16'hA07F, 16'h2200, 16'h3000};
  localparam logic V_HIT [NV] = '{1, 1, 1, 1, 0, 0, 1, 1, 1, 1, 1, 1, 0, 0};
  localparam logic [1:0] V_BUF [NV] = '{0, 0, 0, 0, 0, 0, 1, 1, 1, 1, 2, 2, 0, 0};

  logic clk = 0, rstN = 0, cfgValid = 0, reqValid = 0;
  logic [CAW-1:0] cfgAddr = '0;
  logic [31:0] cfgData = '0;
  logic [AW-1:0] reqAddr = '0, xlateAddr;
  logic hit, miss;
  logic [1:0] hitBuf;
  int tests = 0, fails = 0;

  vframe_xlate #(.NUM_BUF(NB), .ADDR_W(AW)) dut (
    .clk(clk), .rstN(rstN), .cfgValid(cfgValid), .cfgAddr(cfgAddr),
    .cfgData(cfgData), .reqValid(reqValid), .reqAddr(reqAddr),
    .xlateAddr(xlateAddr), .hit(hit), .miss(miss), .hitBuf(hitBuf)
  );

  always #5 clk = ~clk;

  task automatic cfgWrite(input int word, input logic [31:0] data);
    @(negedge clk);
    cfgValid = 1; cfgAddr = CAW'(word); cfgData = data;
    @(negedge clk);
    cfgValid = 0;
  endtask

  task automatic check(input string tag, input logic [AW-1:0] expA,
                       input logic expH, input logic expM, input logic [1:0] expB);
    tests++;
    if (xlateAddr !== expA || hit !== expH || miss !== expM || hitBuf !== expB) begin
      fails++;
      $display("FAIL %s: addr=%h hit=%b miss=%b buf=%0d, expected addr=%h hit=%b miss=%b buf=%0d",
               tag, xlateAddr, hit, miss, hitBuf, expA, expH, expM, expB);
    end
  endtask

  task automatic probe(input logic [AW-1:0] a);
    @(negedge clk);
    reqValid = 1; reqAddr = a;
    #1;
  endtask

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    // R1: reset state, nothing translates
    probe(16'h1000); check("R1 reset passthrough", 16'h1000, 0, 1, 0);
    // R9: no request, no flags
    @(negedge clk); reqValid = 0; #1; check("R9 idle", 16'h1000, 0, 0, 0);

    // R3 descriptors: word 1+4n+f
    cfgWrite(1, 32'h1000); cfgWrite(2, 32'h0280); cfgWrite(3, 32'h8000); cfgWrite(4, 8);
    cfgWrite(5, 32'h2000); cfgWrite(6, 32'h0150); cfgWrite(7, 32'h9000); cfgWrite(8, 6);
    cfgWrite(9, 32'h2100); cfgWrite(10, 32'h0100); cfgWrite(11, 32'hA000); cfgWrite(12, 7);
    cfgWrite(13, 32'h3000); cfgWrite(14, 32'h0080); cfgWrite(15, 32'hB000); cfgWrite(16, 4);
    // R2: descriptors alone do not translate while global mode is off
    probe(16'h1000); check("R2 global off", 16'h1000, 0, 1, 0);
    cfgWrite(0, 32'h0007_0001);

    // table walk: R4 window, R5 wrap, R7 miss, R8 priority, R10 partial last wrap, R2 buffer 3 off
    for (int i = 0; i < NV; i++) begin
      probe(V_ADDR[i]);
      check($sformatf("vector %0d (R4 R5 R7 R8 R10 R2)", i), V_EXP[i], V_HIT[i],
            !V_HIT[i], V_BUF[i]);
    end

    // R2: enable buffer 3 as well
    cfgWrite(0, 32'h000F_0001);
    probe(16'h3011); check("R2 buffer enabled", 16'hB001, 1, 0, 3);
    // R6: address change reflected within the same cycle
    reqAddr = 16'h3012; #1; check("R6 same cycle", 16'hB002, 1, 0, 3);

    // R3: rewrite buffer 0 base, effective only after the edge
    @(negedge clk);
    reqAddr = 16'h1000; cfgValid = 1; cfgAddr = CAW'(1); cfgData = 32'h4000;
    #1; check("R3 before edge", 16'h8000, 1, 0, 0);
    @(negedge clk); cfgValid = 0; #1;
    check("R3 old base gone", 16'h1000, 0, 1, 0);
    reqAddr = 16'h4000; #1; check("R3 new base", 16'h8000, 1, 0, 0);

    // R4: zero length never matches
    cfgWrite(2, 32'h0000);
    probe(16'h4000); check("R4 zero length", 16'h4000, 0, 1, 0);

    // R2: global bit cleared while buffer bits stay set
    cfgWrite(0, 32'h000F_0000);
    probe(16'h2000); check("R2 global cleared", 16'h2000, 0, 1, 0);
    @(negedge clk); reqValid = 0; #1; check("R9 idle after", 16'h2000, 0, 0, 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule